// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single core requests into bus cycles on a microcontroller-style external memory bus. A core asks for a code fetch, a data read or a data write at a 16-bit address. The controller then runs one machine cycle of twelve oscillator periods on the bus, split into six states of two periods each. The low address byte and the data byte take turns on one 8-bit port. The high address byte sits on a second port for the whole cycle. An address-latch strobe in the first state lets an external latch hold the low byte. After that the port carries data. Code reads are qualified by an active-low program-store strobe. Data reads and writes use their own active-low read and write strobes.

A strap input selects where program memory lives. With the strap high, code fetches go to an internal program store through a separate address and data pair, and they finish in one clock with no bus activity. With the strap low, every code fetch runs an external cycle. Data accesses always go out on the bus. Each finished request returns a one-clock done pulse, and read data stays on the read-data output until the next read finishes.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is held and right after it, bus_ale and bus_lo_oe are 0, bus_psen_n, bus_rd_n and bus_wr_n are 1, and rsp_done is 0.
- R2: An external cycle starts on the clock edge that accepts the request and lasts 12 clocks, in six states of 2 clocks each. rsp_done is high for exactly one clock, in the 13th clock after acceptance (t=12, where t=0 is the first clock after the accepting edge).
- R3: bus_ale is high only in state 1 (t=0..1). bus_lo_out carries req_addr[7:0] with bus_lo_oe high from t=0 to t=3.
- R4: In a read, bus_lo_oe is 0 from t=4 to t=11. The strobe is low from t=6 to t=9 and high at every other time. An external code fetch uses bus_psen_n. A data read (req_data=1, req_write=0) uses bus_rd_n.
- R5: In a data write (req_data=1, req_write=1), bus_lo_out carries req_wdata with bus_lo_oe high from t=4 to t=11, and bus_wr_n is low from t=6 to t=9.
- R6: At most one of bus_psen_n, bus_rd_n and bus_wr_n is low at any time. None of them is low while bus_ale is high.
- R7: Read data is the value on bus_lo_in in the last clock before the read or program-store strobe rises (t=9). rsp_rdata shows it from t=10 on and keeps it until the next read completes. A write leaves rsp_rdata unchanged.
- R8: With prog_local=1 when a code fetch is accepted, irom_addr shows the request address at t=0. rsp_done and rsp_rdata=irom_data arrive at t=1. No bus strobe or ALE is asserted. With prog_local=0, the fetch runs an external cycle.
- R9: Data reads and data writes run external cycles whatever the value of prog_local.
- R10: A request is accepted only when the controller is idle and rsp_done is low. Changes on req_* during a cycle, and a req_valid still held in the done clock, have no effect on that cycle's bus outputs.
- R11: When req_data=0, req_write is ignored and the request is a code fetch.
- R12: bus_hi_out carries req_addr[15:8] from t=0 through t=11 of an external cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until rsp_done |
| req_data | input | 1 | 1 = data space, 0 = code fetch |
| req_write | input | 1 | Write when req_data=1 |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Last read or fetch data |
| prog_local | input | 1 | Strap: 1 = internal program store, 0 = external |
| irom_addr | output | 16 | Internal program store address |
| irom_data | input | 8 | Internal program store data |
| bus_ale | output | 1 | Address latch enable, active high |
| bus_psen_n | output | 1 | Program store enable, active low |
| bus_rd_n | output | 1 | Data read strobe, active low |
| bus_wr_n | output | 1 | Data write strobe, active low |
| bus_lo_out | output | 8 | Low port output: A0-A7, then write data |
| bus_lo_oe | output | 1 | Low port output enable |
| bus_lo_in | input | 8 | Low port input: read data |
| bus_hi_out | output | 8 | High port: A8-A15 |

## Verification
The assertions watch the strobes on every cycle. They check that only one strobe is low at a time and never during ALE, that ALE comes with a driven low port, that the port floats under a read strobe and is driven under a write strobe, that the high address and the write data stay steady while a strobe is low, and that done is a single-clock pulse. The bench scenarios cover everything that depends on the request. That means the exact clock of each edge inside the twelve-clock cycle, the choice of strobe by access type, the strap routing to the internal store, the clock at which read data is captured, and the way requests are ignored during a cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int LO_W   = 8;

    // registered controller state
    typedef struct packed {
        logic              busy;
        logic              ext;
        logic              is_data;
        logic              is_write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } ctl_t;

endpackage

// File: rtl/xbus_timebase.sv
module xbus_timebase #(
    parameter int OSC_PER_STATE = 2,
    parameter int STATES_PER_MC = 6,
    localparam int SUB_W = (OSC_PER_STATE > 1) ? $clog2(OSC_PER_STATE) : 1,
    localparam int ST_W  = (STATES_PER_MC > 1) ? $clog2(STATES_PER_MC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            run,
    output logic [ST_W-1:0] st_idx,
    output logic            tick_last,
    output logic            mc_last
);

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [ST_W-1:0]  st;
    } tb_t;

    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSC_PER_STATE - 1);
    localparam logic [ST_W-1:0]  ST_LAST  = ST_W'(STATES_PER_MC - 1);

    tb_t tb_d, tb_q;

    always_comb begin
        tb_d = tb_q;
        if (start) begin
            tb_d = '0;
        end else if (run) begin
            if (tb_q.sub == SUB_LAST) begin
                tb_d.sub = '0;
                tb_d.st  = (tb_q.st == ST_LAST) ? '0 : tb_q.st + 1'b1;
            end else begin
                tb_d.sub = tb_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign st_idx    = tb_q.st;
    assign tick_last = (tb_q.sub == SUB_LAST);
    assign mc_last   = (tb_q.sub == SUB_LAST) && (tb_q.st == ST_LAST);

endmodule

// File: rtl/xbus_strobes.sv
module xbus_strobes #(
    parameter int ST_W          = 3,
    parameter int ADDR_LAST_ST  = 1,
    parameter int STB_FIRST_ST  = 3,
    parameter int STB_LAST_ST   = 4
) (
    input  logic            active,
    input  logic            is_data,
    input  logic            is_write,
    input  logic [ST_W-1:0] st_idx,
    output logic            ale,
    output logic            lo_oe,
    output logic            lo_data_sel,
    output logic            psen_n,
    output logic            rd_n,
    output logic            wr_n
);

    localparam logic [ST_W-1:0] ADDR_LAST = ST_W'(ADDR_LAST_ST);
    localparam logic [ST_W-1:0] STB_FIRST = ST_W'(STB_FIRST_ST);
    localparam logic [ST_W-1:0] STB_LAST  = ST_W'(STB_LAST_ST);

    logic addr_phase_d;
    logic stb_win_d;

    always_comb begin
        addr_phase_d = active && (st_idx <= ADDR_LAST);
        stb_win_d    = active && (st_idx >= STB_FIRST) && (st_idx <= STB_LAST);
        ale          = active && (st_idx == '0);
        lo_oe        = addr_phase_d || (active && is_data && is_write);
        lo_data_sel  = !addr_phase_d;
        psen_n       = !(stb_win_d && !is_data);
        rd_n         = !(stb_win_d && is_data && !is_write);
        wr_n         = !(stb_win_d && is_data && is_write);
    end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int OSC_PER_STATE = 2,
    parameter int STATES_PER_MC = 6,
    parameter int ADDR_LAST_ST  = 1,
    parameter int STB_FIRST_ST  = 3,
    parameter int STB_LAST_ST   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_data,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              prog_local,
    output logic [ADDR_W-1:0] irom_addr,
    input  logic [DATA_W-1:0] irom_data,
    output logic              bus_ale,
    output logic              bus_psen_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [LO_W-1:0]   bus_lo_out,
    output logic              bus_lo_oe,
    input  logic [LO_W-1:0]   bus_lo_in,
    output logic [LO_W-1:0]   bus_hi_out
);

    localparam int ST_W = (STATES_PER_MC > 1) ? $clog2(STATES_PER_MC) : 1;
    localparam logic [ST_W-1:0] CAP_ST = ST_W'(STB_LAST_ST);

    ctl_t            ctl_d, ctl_q;
    logic            tb_start;
    logic            tb_run;
    logic [ST_W-1:0] st_idx;
    logic            tick_last;
    logic            mc_last;
    logic            lo_data_sel;
    logic            capture_d;

    xbus_timebase #(
        .OSC_PER_STATE (OSC_PER_STATE),
        .STATES_PER_MC (STATES_PER_MC)
    ) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (tb_start),
        .run       (tb_run),
        .st_idx    (st_idx),
        .tick_last (tick_last),
        .mc_last   (mc_last)
    );

    xbus_strobes #(
        .ST_W         (ST_W),
        .ADDR_LAST_ST (ADDR_LAST_ST),
        .STB_FIRST_ST (STB_FIRST_ST),
        .STB_LAST_ST  (STB_LAST_ST)
    ) u_strobes (
        .active      (ctl_q.busy && ctl_q.ext),
        .is_data     (ctl_q.is_data),
        .is_write    (ctl_q.is_write),
        .st_idx      (st_idx),
        .ale         (bus_ale),
        .lo_oe       (bus_lo_oe),
        .lo_data_sel (lo_data_sel),
        .psen_n      (bus_psen_n),
        .rd_n        (bus_rd_n),
        .wr_n        (bus_wr_n)
    );

    assign tb_run = ctl_q.busy && ctl_q.ext;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tb_start   = 1'b0;
        capture_d  = ctl_q.busy && ctl_q.ext && !ctl_q.is_write &&
                     (st_idx == CAP_ST) && tick_last;
        if (!ctl_q.busy) begin
            // a request held through the done clock is not taken again
            if (req_valid && !ctl_q.done) begin
                tb_start       = 1'b1;
                ctl_d.busy     = 1'b1;
                ctl_d.is_data  = req_data;
                ctl_d.is_write = req_data && req_write;
                ctl_d.ext      = req_data || !prog_local;
                ctl_d.addr     = req_addr;
                ctl_d.wdata    = req_wdata;
            end
        end else if (!ctl_q.ext) begin
            ctl_d.rdata = irom_data;
            ctl_d.busy  = 1'b0;
            ctl_d.done  = 1'b1;
        end else begin
            if (capture_d) ctl_d.rdata = bus_lo_in;
            if (mc_last) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rsp_done   = ctl_q.done;
    assign rsp_rdata  = ctl_q.rdata;
    assign irom_addr  = ctl_q.addr;
    assign bus_hi_out = ctl_q.addr[ADDR_W-1 -: LO_W];
    assign bus_lo_out = lo_data_sel ? ctl_q.wdata : ctl_q.addr[LO_W-1:0];

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_ale,
    input logic       bus_psen_n,
    input logic       bus_rd_n,
    input logic       bus_wr_n,
    input logic       bus_lo_oe,
    input logic [7:0] bus_lo_out,
    input logic [7:0] bus_hi_out,
    input logic       rsp_done
);

    logic any_stb;
    assign any_stb = !bus_psen_n || !bus_rd_n || !bus_wr_n;

    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!bus_psen_n, !bus_rd_n, !bus_wr_n}) <= 1);

    p_ale_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> !any_stb);

    p_ale_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> bus_lo_oe);

    p_read_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_psen_n) |-> !bus_lo_oe);

    p_write_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> bus_lo_oe);

    p_write_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_n && $past(!bus_wr_n)) |-> $stable(bus_lo_out));

    p_hi_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (any_stb && $past(any_stb)) |-> $stable(bus_hi_out));

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ale    (bus_ale),
    .bus_psen_n (bus_psen_n),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .bus_lo_oe  (bus_lo_oe),
    .bus_lo_out (bus_lo_out),
    .bus_hi_out (bus_hi_out),
    .rsp_done   (rsp_done)
);

// File: tb/tb_xbus_ctrl.sv
module tb_xbus_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_data = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic        prog_local = 1'b0;
    logic [15:0] irom_addr;
    logic [7:0]  irom_data;
    logic        bus_ale, bus_psen_n, bus_rd_n, bus_wr_n, bus_lo_oe;
    logic [7:0]  bus_lo_out, bus_lo_in, bus_hi_out;
    logic [7:0]  mem_val = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] exp_rdata = '0;

    always #5 clk = ~clk;

    // external memory answers only while a read strobe is low
    assign bus_lo_in = (!bus_psen_n || !bus_rd_n) ? mem_val : 8'h00;
    assign irom_data = irom_addr[7:0] ^ irom_addr[15:8] ^ 8'h3C;

    xbus_ctrl dut (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // {ale, lo_oe, psen_n, rd_n, wr_n, done} expected at clock t of a request
    function automatic logic [5:0] exp_ctl(input int t, input bit d, input bit w,
                                           input bit ext);
        bit stb;
        if (!ext) return {5'b00111, t == 1};
        stb = (t >= 6) && (t <= 9);
        return {t < 2, (t < 4) || (w && t < 12), !(stb && !d),
                !(stb && d && !w), !(stb && d && w), t == 12};
    endfunction

    function automatic logic [5:0] act_ctl();
        return {bus_ale, bus_lo_oe, bus_psen_n, bus_rd_n, bus_wr_n, rsp_done};
    endfunction

    task automatic run_req(input bit d, input bit w, input logic [15:0] a,
                           input logic [7:0] wd, input bit strap,
                           input logic [7:0] mv, input bit bump);
        bit ext, we;
        int last;
        string tag;
        ext  = d || !strap;
        we   = d && w;
        last = ext ? 12 : 1;
        tag  = !ext ? "R8" : (we ? "R2 R3 R5 R9" : (d ? "R2 R3 R4 R9" : "R2 R3 R4 R8 R11"));
        @(negedge clk);
        req_valid = 1'b1; req_data = d; req_write = w; req_addr = a;
        req_wdata = wd; prog_local = strap; mem_val = mv;
        for (int t = 0; t <= last; t++) begin
            @(negedge clk);
            check(act_ctl() == exp_ctl(t, d, we, ext), tag, act_ctl(), exp_ctl(t, d, we, ext));
            if (ext && t < 12)
                check(bus_hi_out == a[15:8], "R12", bus_hi_out, a[15:8]);
            if (ext && exp_ctl(t, d, we, ext)[4])
                check(bus_lo_out == ((t < 4) ? a[7:0] : wd), bump ? "R10 R3 R5" : "R3 R5",
                      bus_lo_out, (t < 4) ? a[7:0] : wd);
            if (!ext && t == 0)
                check(irom_addr == a, "R8", irom_addr, a);
            if (ext && !we && t == 10)
                check(rsp_rdata == mv, "R7", rsp_rdata, mv);
            if (t == 0 && bump) begin
                req_addr = ~a; req_wdata = ~wd; req_data = ~d; req_write = ~w;
                prog_local = ~strap;
            end
            if (t == last) begin
                if (!ext) exp_rdata = a[7:0] ^ a[15:8] ^ 8'h3C;
                else if (!we) exp_rdata = mv;
                check(rsp_rdata == exp_rdata, we ? "R7 write keeps" : "R7 R8", rsp_rdata, exp_rdata);
                if (bump) req_valid = 1'b1;
            end
        end
        if (bump) begin
            // valid still held in the done clock must not start a new cycle (R10)
            @(negedge clk);
            check({bus_ale, rsp_done} == 2'b00, "R10", {bus_ale, rsp_done}, 2'b00);
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(act_ctl() == 6'b001110, "R1 in reset", act_ctl(), 6'b001110);
        rst_n = 1'b1;
        @(negedge clk);
        check(act_ctl() == 6'b001110, "R1 after reset", act_ctl(), 6'b001110);
        // directed corners
        run_req(1'b0, 1'b0, 16'hFFFF, 8'h00, 1'b0, 8'hC3, 1'b0);
        run_req(1'b1, 1'b0, 16'h0000, 8'h11, 1'b0, 8'h5A, 1'b0);
        run_req(1'b1, 1'b1, 16'h1000, 8'h55, 1'b0, 8'hEE, 1'b0);
        run_req(1'b0, 1'b0, 16'h0123, 8'h00, 1'b1, 8'h77, 1'b0);
        run_req(1'b1, 1'b0, 16'h8001, 8'h00, 1'b1, 8'h99, 1'b0);
        run_req(1'b1, 1'b1, 16'h7FFE, 8'hA0, 1'b1, 8'h00, 1'b0);
        run_req(1'b0, 1'b1, 16'h4242, 8'hFF, 1'b0, 8'h24, 1'b0);
        run_req(1'b1, 1'b0, 16'hBEEF, 8'h01, 1'b0, 8'h81, 1'b1);
        run_req(1'b0, 1'b0, 16'hCAFE, 8'h02, 1'b1, 8'h18, 1'b1);
        begin
            void'($urandom(32'd2024));
            for (int i = 0; i < 60; i++) begin
                logic [31:0] r;
                r = $urandom;
                run_req(r[0], r[1], 16'($urandom), 8'($urandom), r[2],
                        8'($urandom), r[5:3] == 3'd0);
            end
        end
        repeat (2) @(negedge clk);
        check(act_ctl() == 6'b001110, "R1 idle", act_ctl(), 6'b001110);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule